// File: doc/BRIEF.md
# Wavetable Voice with Running-Access Quirks

This block is a 4-bit wavetable sound voice. A 16-byte wave store holds 32 four-bit samples that the voice steps through in a loop. A down-counting period timer is loaded from an 11-bit frequency value, and each time the timer expires the voice moves to the next sample. A 2-bit volume code scales the held sample by a right shift. A trigger pulse restarts the voice and loads a length value.

The wave store is reached over a small byte bus that has a write strobe and a combinational read path. While the voice is stopped, the bus reaches the store directly by address. While the voice runs, every access is steered to the byte being played, whatever address is driven. In the legacy mode, such an access succeeds only in the single clock that follows a sample step; outside that clock, reads return 0xFF and writes are lost. Also in the legacy mode, a trigger that lands inside that one-clock window overwrites the first bytes of the store. A mode input selects this legacy behaviour or the relaxed colour behaviour, in which no gating or corruption happens.

Top module: `wavetable_voice`

## Requirements
- R1: Trigger loads the period timer with 2048 − freq. From then on the timer counts down by one per clock. When the count is 1 it reloads with 2048 − freq and the 5-bit play position advances by one, wrapping from 31 to 0. A timer that holds 0 stays still.
- R2: On each step the sample for the new position is latched. An even position plays bits [7:4] of byte position>>1, and an odd position plays bits [3:0].
- R3: level equals the held sample shifted right by 4, 0, 1 or 2 for vol_code 0, 1, 2 or 3.
- R4: hold_active is 1 in the clock that follows a step, and 0 after any clock with no step.
- R5: While ch_enabled is 1, ram_rdata shows byte position>>1 whatever ram_addr is. In legacy mode (color_mode=0) it shows 0xFF when hold_active is 0.
- R6: While ch_enabled is 1, a write goes to byte position>>1. In legacy mode the write is discarded when hold_active is 0.
- R7: In legacy mode, a trigger while hold_active is 1 corrupts the store. If i = position>>1 is 0 to 3, byte 0 takes byte i. Otherwise bytes 0 to 3 take bytes (i & ~3) to (i & ~3)+3. A trigger with hold_active at 0, or in colour mode, leaves the store unchanged.
- R8: A trigger sets ch_enabled to dac_en and clears the position, the sample and the hold flag. It sets length to 256 if length is 0 and otherwise leaves it unchanged. len_load writes len_value into length when no trigger is present.
- R9: While ch_enabled is 0, reads and writes reach byte ram_addr directly.
- R10: After reset, ch_enabled, level, play_pos, hold_active, length and every store byte are 0, and the voice does not step.
- R11: In colour mode (color_mode=1), running reads and writes are never gated by hold_active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| color_mode | input | 1 | 1 selects relaxed colour behaviour, 0 selects legacy quirks |
| dac_en | input | 1 | Value copied into ch_enabled on trigger |
| freq | input | 11 | Frequency value; the period is 2048 − freq |
| vol_code | input | 2 | Volume shift code |
| trigger | input | 1 | Restart pulse |
| len_load | input | 1 | Loads len_value into length |
| len_value | input | 9 | Length load value |
| ram_addr | input | 4 | Store byte address |
| ram_wr | input | 1 | Store write strobe |
| ram_wdata | input | 8 | Store write data |
| ram_rdata | output | 8 | Store read data (combinational) |
| level | output | 4 | Scaled output sample |
| ch_enabled | output | 1 | Voice running |
| play_pos | output | 5 | Current nibble position |
| hold_active | output | 1 | One-clock access window after a step |
| length | output | 9 | Length value |

## Verification
The voice is driven at two step rates. With freq 2047 it steps every clock, so the access window is always open. With freq 2046 it steps every second clock, so the window opens and closes on alternate clocks. This tells correctly gated accesses apart from accesses that ignore the window or that use the driven address. A vector table covers every volume code with different byte values, which shows the shift amounts and the nibble order. Triggers are fired at positions whose byte index is below 4, at or above 4, and with the window closed, which separates the two corruption forms from no corruption. A full 32-step lap checks the position wrap.

// File: rtl/wt_pkg.sv
package wt_pkg;

    typedef enum logic [1:0] {
        VOL_MUTE    = 2'd0,
        VOL_FULL    = 2'd1,
        VOL_HALF    = 2'd2,
        VOL_QUARTER = 2'd3
    } vol_e;

    localparam int SAMPLE_W = 4;
    localparam int BYTE_W   = 8;
    localparam int GROUP    = 4;

    function automatic logic [SAMPLE_W-1:0] scale_sample(
        input logic [SAMPLE_W-1:0] s,
        input vol_e                v
    );
        case (v)
            VOL_FULL:    scale_sample = s;
            VOL_HALF:    scale_sample = s >> 1;
            VOL_QUARTER: scale_sample = s >> 2;
            default:     scale_sample = '0;
        endcase
    endfunction

    function automatic logic [SAMPLE_W-1:0] pick_nibble(
        input logic [BYTE_W-1:0] b,
        input logic              odd
    );
        pick_nibble = odd ? b[3:0] : b[7:4];
    endfunction

endpackage

// File: rtl/wt_stepper.sv
module wt_stepper #(
    parameter int FREQ_W = 11,
    parameter int POS_W  = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         trig,
    input  logic [FREQ_W-1:0]            freq,
    input  logic [wt_pkg::SAMPLE_W-1:0]  nib_next,
    output logic [POS_W-1:0]             pos,
    output logic                         hold,
    output logic [wt_pkg::SAMPLE_W-1:0]  sample
);
    localparam int PER_W = FREQ_W + 1;
    localparam logic [PER_W-1:0] PER_TOP = PER_W'(2 ** FREQ_W);

    logic [PER_W-1:0] period;
    logic [PER_W-1:0] reload;
    logic             step;

    assign reload = PER_TOP - PER_W'(freq);
    assign step   = (period == PER_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            period <= '0;
            pos    <= '0;
            hold   <= 1'b0;
            sample <= '0;
        end else if (trig) begin
            period <= reload;
            pos    <= '0;
            hold   <= 1'b0;
            sample <= '0;
        end else if (step) begin
            period <= reload;
            pos    <= pos + POS_W'(1);
            hold   <= 1'b1;
            sample <= nib_next;
        end else begin
            if (period != '0) period <= period - PER_W'(1);
            hold <= 1'b0;
        end
    end

    p_step_advance_r1: assert property (@(posedge clk) disable iff (rst)
        (step && !trig) |=> (pos == $past(pos) + POS_W'(1)));
    p_reload_r1: assert property (@(posedge clk) disable iff (rst)
        trig |=> (period == PER_TOP - PER_W'($past(freq))));
    p_hold_rise_r4: assert property (@(posedge clk) disable iff (rst)
        (step && !trig) |=> hold);
    p_hold_one_r4: assert property (@(posedge clk) disable iff (rst)
        (!step) |=> !hold);
    p_trig_clear_r8: assert property (@(posedge clk) disable iff (rst)
        trig |=> (pos == '0 && !hold && sample == '0));

endmodule

// File: rtl/wt_store.sv
module wt_store #(
    parameter int POS_W = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         color,
    input  logic                         en,
    input  logic                         hold,
    input  logic                         trig,
    input  logic [POS_W-1:0]             pos,
    input  logic [POS_W-2:0]             addr,
    input  logic                         wr,
    input  logic [wt_pkg::BYTE_W-1:0]    wdata,
    output logic [wt_pkg::BYTE_W-1:0]    rdata,
    output logic [wt_pkg::SAMPLE_W-1:0]  nib_next
);
    import wt_pkg::*;

    localparam int IDX_W = POS_W - 1;
    localparam int BYTES = 2 ** IDX_W;

    logic [BYTES-1:0][BYTE_W-1:0] mem;
    logic [IDX_W-1:0]             idx;
    logic [POS_W-1:0]             nxt;
    logic                         gate_open;
    logic                         corrupt;

    assign idx       = pos[POS_W-1:1];
    assign nxt       = pos + POS_W'(1);
    assign gate_open = color || hold;
    assign corrupt   = trig && !color && hold;
    assign nib_next  = pick_nibble(mem[nxt[POS_W-1:1]], nxt[0]);

    always_comb begin
        if (!en)            rdata = mem[addr];
        else if (gate_open) rdata = mem[idx];
        else                rdata = 8'hFF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else begin
            if (corrupt) begin
                if (idx < IDX_W'(GROUP)) begin
                    mem[0] <= mem[idx];
                end else begin
                    for (int k = 0; k < GROUP; k++)
                        mem[k] <= mem[{idx[IDX_W-1:2], 2'(k)}];
                end
            end
            if (wr) begin
                if (!en)            mem[addr] <= wdata;
                else if (gate_open) mem[idx]  <= wdata;
            end
        end
    end

    p_drop_write_r6: assert property (@(posedge clk) disable iff (rst)
        (en && !color && !hold && wr && !trig) |=> $stable(mem));
    p_corrupt_low_r7: assert property (@(posedge clk) disable iff (rst)
        (corrupt && idx < IDX_W'(GROUP) && !wr) |=> (mem[0] == $past(mem[idx])));
    p_no_corrupt_r7: assert property (@(posedge clk) disable iff (rst)
        (trig && !hold && !wr) |=> $stable(mem));

endmodule

// File: rtl/wavetable_voice.sv
module wavetable_voice #(
    parameter int FREQ_W  = 11,
    parameter int POS_W   = 5,
    parameter int LEN_MAX = 256,
    localparam int LEN_W  = $clog2(LEN_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              color_mode,
    input  logic              dac_en,
    input  logic [FREQ_W-1:0] freq,
    input  logic [1:0]        vol_code,
    input  logic              trigger,
    input  logic              len_load,
    input  logic [LEN_W-1:0]  len_value,
    input  logic [POS_W-2:0]  ram_addr,
    input  logic              ram_wr,
    input  logic [7:0]        ram_wdata,
    output logic [7:0]        ram_rdata,
    output logic [3:0]        level,
    output logic              ch_enabled,
    output logic [POS_W-1:0]  play_pos,
    output logic              hold_active,
    output logic [LEN_W-1:0]  length
);
    import wt_pkg::*;

    logic [SAMPLE_W-1:0] nib_next;
    logic [SAMPLE_W-1:0] sample;

    wt_stepper #(.FREQ_W(FREQ_W), .POS_W(POS_W)) u_step (
        .clk      (clk),
        .rst      (rst),
        .trig     (trigger),
        .freq     (freq),
        .nib_next (nib_next),
        .pos      (play_pos),
        .hold     (hold_active),
        .sample   (sample)
    );

    wt_store #(.POS_W(POS_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .color    (color_mode),
        .en       (ch_enabled),
        .hold     (hold_active),
        .trig     (trigger),
        .pos      (play_pos),
        .addr     (ram_addr),
        .wr       (ram_wr),
        .wdata    (ram_wdata),
        .rdata    (ram_rdata),
        .nib_next (nib_next)
    );

    assign level = scale_sample(sample, vol_e'(vol_code));

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_enabled <= 1'b0;
            length     <= '0;
        end else if (trigger) begin
            ch_enabled <= dac_en;
            if (length == '0) length <= LEN_W'(LEN_MAX);
        end else if (len_load) begin
            length <= len_value;
        end
    end

    p_len_reload_r8: assert property (@(posedge clk) disable iff (rst)
        (trigger && length == '0) |=> (length == LEN_W'(LEN_MAX)));
    p_enable_follow_r8: assert property (@(posedge clk) disable iff (rst)
        trigger |=> (ch_enabled == $past(dac_en)));
    p_closed_read_r5: assert property (@(posedge clk) disable iff (rst)
        (ch_enabled && !color_mode && !hold_active) |-> (ram_rdata == 8'hFF));
    p_mute_r3: assert property (@(posedge clk) disable iff (rst)
        (vol_code == 2'd0) |-> (level == 4'd0));

endmodule

// File: tb/test_wavetable_voice.sv
`timescale 1ns/1ps
module test_wavetable_voice;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        color_mode = 1'b0;
    logic        dac_en = 1'b0;
    logic [10:0] freq = 11'd0;
    logic [1:0]  vol_code = 2'd1;
    logic        trigger = 1'b0;
    logic        len_load = 1'b0;
    logic [8:0]  len_value = 9'd0;
    logic [3:0]  ram_addr = 4'd0;
    logic        ram_wr = 1'b0;
    logic [7:0]  ram_wdata = 8'd0;
    logic [7:0]  ram_rdata;
    logic [3:0]  level;
    logic        ch_enabled;
    logic [4:0]  play_pos;
    logic        hold_active;
    logic [8:0]  length;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wavetable_voice i_wavetable_voice (
        .clk(clk), .rst(rst), .color_mode(color_mode), .dac_en(dac_en),
        .freq(freq), .vol_code(vol_code), .trigger(trigger),
        .len_load(len_load), .len_value(len_value), .ram_addr(ram_addr),
        .ram_wr(ram_wr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .level(level), .ch_enabled(ch_enabled), .play_pos(play_pos),
        .hold_active(hold_active), .length(length)
    );

    // byte0 value, volume code, expected level after the first step (low nibble)
    localparam logic [13:0] VEC [6] = '{
        {8'h3F, 2'd1, 4'hF},
        {8'h3F, 2'd2, 4'h7},
        {8'h3F, 2'd3, 4'h3},
        {8'h3F, 2'd0, 4'h0},
        {8'hA6, 2'd2, 4'h3},
        {8'h59, 2'd1, 4'h9}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_byte(input logic [3:0] a, input logic [7:0] d);
        ram_addr = a; ram_wdata = d; ram_wr = 1'b1;
        tick();
        ram_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
        ram_addr = a;
        #0.5;
        chk(ram_rdata == exp, req, ram_rdata, exp);
    endtask

    task automatic fire(input logic dac, input logic [10:0] f, input logic col);
        dac_en = dac; freq = f; color_mode = col; trigger = 1'b1;
        tick();
        trigger = 1'b0;
    endtask

    task automatic stop_clean();
        fire(1'b0, 11'd2047, 1'b1);
        color_mode = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        repeat (3) tick();
        // R10 reset state, timer halted at period 0
        chk(ch_enabled == 1'b0, "R10 enabled", ch_enabled, 0);
        chk(level == 4'd0, "R10 level", level, 0);
        chk(play_pos == 5'd0, "R10 position halted", play_pos, 0);
        chk(hold_active == 1'b0, "R10 hold", hold_active, 0);
        chk(length == 9'd0, "R10 length", length, 0);
        rd_chk(4'd0, 8'h00, "R10 store cleared");

        // R9 direct access while stopped
        wr_byte(4'd5, 8'h5A);
        rd_chk(4'd5, 8'h5A, "R9 direct write/read");

        // gating at half rate (period 2)
        wr_byte(4'd0, 8'hC3);
        wr_byte(4'd1, 8'h5E);
        vol_code = 2'd1;
        fire(1'b1, 11'd2046, 1'b0);
        chk(ch_enabled == 1'b1, "R8 enable from dac", ch_enabled, 1);
        chk(length == 9'd256, "R8 length reload", length, 256);
        chk(play_pos == 5'd0 && hold_active == 1'b0, "R8 cleared", play_pos, 0);
        rd_chk(4'd7, 8'hFF, "R5 closed read");
        ram_wdata = 8'h99; ram_wr = 1'b1;
        tick();
        ram_wr = 1'b0;
        color_mode = 1'b1;
        rd_chk(4'd7, 8'hC3, "R6 dropped write / R11 colour read");
        color_mode = 1'b0;
        chk(play_pos == 5'd0, "R1 no step before period expires", play_pos, 0);
        tick();
        chk(play_pos == 5'd1, "R1 step after period", play_pos, 1);
        chk(hold_active == 1'b1, "R4 window open", hold_active, 1);
        chk(level == 4'h3, "R2 odd position low nibble", level, 3);
        rd_chk(4'd9, 8'hC3, "R5 open read redirected");
        ram_wdata = 8'h44; ram_wr = 1'b1;
        tick();
        ram_wr = 1'b0;
        chk(hold_active == 1'b0, "R4 window closes", hold_active, 0);
        stop_clean();
        chk(ch_enabled == 1'b0, "R8 disable from dac", ch_enabled, 0);
        rd_chk(4'd0, 8'h44, "R6 open write redirected");
        rd_chk(4'd9, 8'h00, "R6 write not at driven address");
        rd_chk(4'd1, 8'h5E, "R9 neighbour intact");

        // volume / nibble vector table
        for (int v = 0; v < 6; v++) begin
            wr_byte(4'd0, VEC[v][13:6]);
            vol_code = VEC[v][5:4];
            fire(1'b1, 11'd2047, 1'b0);
            tick();
            chk(level == VEC[v][3:0], "R3 volume shift", level, VEC[v][3:0]);
            stop_clean();
        end

        // position wrap: byte0=A6, byte15=0
        wr_byte(4'd0, 8'hA6);
        vol_code = 2'd1;
        fire(1'b1, 11'd2047, 1'b0);
        repeat (31) tick();
        chk(play_pos == 5'd31, "R1 position 31", play_pos, 31);
        tick();
        chk(play_pos == 5'd0, "R1 wrap to 0", play_pos, 0);
        chk(level == 4'hA, "R2 even position high nibble", level, 4'hA);
        stop_clean();

        // corruption, byte index >= 4
        for (int i = 0; i < 8; i++) wr_byte(4'(i), 8'h10 + 8'(i));
        fire(1'b1, 11'd2047, 1'b0);
        repeat (9) tick();
        chk(play_pos == 5'd9, "R7 reached position 9", play_pos, 9);
        fire(1'b0, 11'd2047, 1'b0);
        for (int i = 0; i < 4; i++)
            rd_chk(4'(i), 8'h14 + 8'(i), "R7 group copy");
        rd_chk(4'd4, 8'h14, "R7 source intact");

        // corruption, byte index < 4
        for (int i = 0; i < 4; i++) wr_byte(4'(i), 8'h10 + 8'(i));
        fire(1'b1, 11'd2047, 1'b0);
        repeat (5) tick();
        fire(1'b0, 11'd2047, 1'b0);
        rd_chk(4'd0, 8'h12, "R7 single byte copy");
        rd_chk(4'd1, 8'h11, "R7 byte1 untouched");

        // trigger with window closed: no corruption
        fire(1'b1, 11'd2046, 1'b0);
        fire(1'b0, 11'd2046, 1'b0);
        rd_chk(4'd0, 8'h12, "R7 closed window no corruption");

        // colour mode trigger inside window: no corruption
        fire(1'b1, 11'd2047, 1'b0);
        repeat (9) tick();
        fire(1'b0, 11'd2047, 1'b1);
        color_mode = 1'b0;
        rd_chk(4'd0, 8'h12, "R11 colour trigger no corruption");

        // length load kept when nonzero
        len_value = 9'd20; len_load = 1'b1;
        tick();
        len_load = 1'b0;
        chk(length == 9'd20, "R8 length load", length, 20);
        fire(1'b1, 11'd2047, 1'b1);
        chk(length == 9'd20, "R8 nonzero length kept", length, 20);
        stop_clean();

        done = 1'b1;
        summary();
    end
endmodule